// File: doc/BRIEF.md
# T1-into-E1 Timeslot Embedding Mapper

This block accepts a serial T1 frame (a framing bit followed by 24 eight-bit timeslots, 193 bits) and replays it as a 256-bit E1-rate PCM frame of 32 timeslots. The T1 content lands at fixed, non-contiguous positions. E1 slots 0 and 16 are skipped. T1 slots 1 to 15 occupy E1 slots 1 to 15. T1 slots 16 to 24 occupy E1 slots 17 to 25. The T1 framing bit rides in the first bit of E1 slot 26.

Incoming bits are written into one half of a two-bank store. When a T1 frame completes, that bank becomes the latest full frame. At every E1 frame start the output side locks onto the latest full bank and plays it out one bit per output strobe. This allows the input and output frame phases to differ by up to one frame. Alongside the data bit, the block drives a marker that is high during unassigned timeslots. Positions that carry no T1 content are driven to all ones. An enable input turns the embedding on. While it is low, every output position is fill and every slot is marked unassigned.

Top module: `t1e1_embed_mapper`

## Requirements
- R1: After reset, and before the first output strobe, `e1_pcm` is 1 and `e1_unasg` is 1.
- R2: E1 slots 1 to 15 carry T1 slots 1 to 15, with `e1_unasg` low. Within each slot, bits are sent in the order they were received, so the MSB is sent first. The T1 serial input is framing bit first, then slot 1 MSB to LSB, then slot 2, and so on.
- R3: E1 slots 17 to 25 carry T1 slots 16 to 24 in the same bit order, with `e1_unasg` low.
- R4: Bit 0 (first sent) of E1 slot 26 carries the T1 framing bit. Bits 1 to 7 of slot 26 are 1. `e1_unasg` is low for all of slot 26.
- R5: During E1 slots 0, 16 and 27 to 31, `e1_unasg` is 1 and `e1_pcm` is 1.
- R6: While `en` is low at an output strobe, that bit shows `e1_pcm` = 1 and `e1_unasg` = 1, whatever the slot.
- R7: Outputs change only on the clock edge that samples `e1_adv` high, and they then show the bit for the position just reached. Position 0 is the position marked by `e1_fsync`. Without `e1_adv` the outputs hold.
- R8: Each E1 frame plays the last T1 frame that was complete at its frame start. A T1 frame completed partway through an E1 frame appears only from the next E1 frame onward.
- R9: Before any T1 frame has completed, the data and framing positions output 1 with `e1_unasg` low.
- R10: T1 bits received without a preceding `t1_fsync` are ignored. A `t1_fsync` restarts the write at the framing bit, and a partial frame never becomes the played frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Embedding enable |
| t1_bit | input | 1 | Serial T1 data bit |
| t1_adv | input | 1 | T1 bit strobe |
| t1_fsync | input | 1 | Marks the T1 framing bit, valid with t1_adv |
| e1_adv | input | 1 | E1 output bit strobe |
| e1_fsync | input | 1 | Marks E1 bit 0, valid with e1_adv |
| e1_pcm | output | 1 | E1 PCM output bit |
| e1_unasg | output | 1 | High during unassigned E1 timeslots |

## Verification
The slot seams are the main targets. A design that failed to skip slot 16 would shift T1 slots 16 to 24 one slot early, which shows up as miscompares across E1 slots 16 to 25. A misplaced framing bit would show up in slot 26, or as data in slots 27 to 31. A T1 frame is also completed while an E1 frame is half played out; a design that switches banks immediately rather than at the frame start would tear that frame. Further tests cover stray T1 bits with no frame strobe, a partial frame cut short by a new strobe, the enable dropping mid-frame, and idle cycles between output strobes. Each of these exposes a writer that accepts unframed data, a mapper that ignores the enable, or outputs that move without a strobe.

// File: rtl/t1e1_pkg.sv
package t1e1_pkg;
  localparam int unsigned SLOT_BITS_D = 8;
  localparam int unsigned T1_SLOTS_D  = 24;
  localparam int unsigned E1_SLOTS_D  = 32;
  localparam int unsigned SIG_SLOT_D  = 16;
  localparam int unsigned FBIT_SLOT_D = 26;

  typedef enum logic [1:0] {
    POS_UNASG = 2'd0,
    POS_DATA  = 2'd1,
    POS_FBIT  = 2'd2,
    POS_FILL  = 2'd3
  } pos_kind_e;
endpackage

// File: rtl/t1_frame_capture.sv
module t1_frame_capture #(
  parameter int unsigned FRAME_BITS = 193
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bit_in,
  input  logic                         adv,
  input  logic                         fsync,
  output logic [1:0][FRAME_BITS-1:0]   banks,
  output logic                         full_bank,
  output logic                         have_frame
);
  localparam int unsigned IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

  logic [1:0][FRAME_BITS-1:0] banks_q, banks_n;
  logic [IW-1:0] wpos_q, wpos_n;
  logic          wbank_q, wbank_n;
  logic          live_q, live_n;
  logic          full_q, full_n;
  logic          have_q, have_n;
  logic          wr;
  logic [IW-1:0] idx;

  always_comb begin
    banks_n = banks_q;
    wpos_n  = wpos_q;
    wbank_n = wbank_q;
    live_n  = live_q;
    full_n  = full_q;
    have_n  = have_q;
    wr      = 1'b0;
    idx     = '0;
    if (adv && fsync) begin
      wr  = 1'b1;
      idx = '0;
    end else if (adv && live_q) begin
      wr  = 1'b1;
      idx = wpos_q + 1'b1;
    end
    if (wr) begin
      banks_n[wbank_q][idx] = bit_in;
      wpos_n = idx;
      live_n = 1'b1;
      if (idx == LAST_IDX) begin
        live_n  = 1'b0;
        full_n  = wbank_q;
        wbank_n = ~wbank_q;
        have_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpos_q  <= '0;
      wbank_q <= 1'b0;
      live_q  <= 1'b0;
      full_q  <= 1'b0;
      have_q  <= 1'b0;
    end else begin
      wpos_q  <= wpos_n;
      wbank_q <= wbank_n;
      live_q  <= live_n;
      full_q  <= full_n;
      have_q  <= have_n;
    end
  end

  always_ff @(posedge clk) begin
    banks_q <= banks_n;
  end

  assign banks      = banks_q;
  assign full_bank  = full_q;
  assign have_frame = have_q;
endmodule

// File: rtl/e1_slot_map.sv
module e1_slot_map
  import t1e1_pkg::*;
#(
  parameter int unsigned SLOT_BITS = SLOT_BITS_D,
  parameter int unsigned T1_SLOTS  = T1_SLOTS_D,
  parameter int unsigned E1_SLOTS  = E1_SLOTS_D,
  parameter int unsigned SIG_SLOT  = SIG_SLOT_D,
  parameter int unsigned FBIT_SLOT = FBIT_SLOT_D,
  localparam int unsigned PW = $clog2(E1_SLOTS * SLOT_BITS),
  localparam int unsigned IW = $clog2(T1_SLOTS * SLOT_BITS + 1)
) (
  input  logic [PW-1:0] pos,
  output pos_kind_e     kind,
  output logic [IW-1:0] src_idx
);
  localparam int unsigned BW = $clog2(SLOT_BITS);
  localparam int unsigned SW = PW - BW;

  logic [SW-1:0] slot;
  logic [BW-1:0] bitp;
  logic [SW-1:0] t1slot;

  assign slot = pos[PW-1:BW];
  assign bitp = pos[BW-1:0];

  always_comb begin
    kind   = POS_UNASG;
    t1slot = '0;
    if (slot == '0 || slot == SW'(SIG_SLOT)) begin
      kind = POS_UNASG;
    end else if (slot < SW'(SIG_SLOT)) begin
      kind   = POS_DATA;
      t1slot = slot;
    end else if (slot < SW'(FBIT_SLOT)) begin
      kind   = POS_DATA;
      t1slot = slot - 1'b1;
    end else if (slot == SW'(FBIT_SLOT)) begin
      kind = (bitp == '0) ? POS_FBIT : POS_FILL;
    end
    src_idx = IW'(1 + (int'(t1slot) - 1) * int'(SLOT_BITS) + int'(bitp));
    if (kind != POS_DATA) src_idx = '0;
  end
endmodule

// File: rtl/t1e1_embed_mapper.sv
module t1e1_embed_mapper
  import t1e1_pkg::*;
#(
  parameter int unsigned SLOT_BITS = SLOT_BITS_D,
  parameter int unsigned T1_SLOTS  = T1_SLOTS_D,
  parameter int unsigned E1_SLOTS  = E1_SLOTS_D,
  parameter int unsigned SIG_SLOT  = SIG_SLOT_D,
  parameter int unsigned FBIT_SLOT = FBIT_SLOT_D
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic t1_bit,
  input  logic t1_adv,
  input  logic t1_fsync,
  input  logic e1_adv,
  input  logic e1_fsync,
  output logic e1_pcm,
  output logic e1_unasg
);
  localparam int unsigned T1_BITS = T1_SLOTS * SLOT_BITS + 1;
  localparam int unsigned E1_BITS = E1_SLOTS * SLOT_BITS;
  localparam int unsigned PW      = $clog2(E1_BITS);
  localparam int unsigned IW      = $clog2(T1_BITS);
  localparam logic [PW-1:0] LAST_POS = PW'(E1_BITS - 1);

  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic [1:0][T1_BITS-1:0] banks;
  logic                    full_bank;
  logic                    have_frame;

  t1_frame_capture #(.FRAME_BITS(T1_BITS)) u_cap (
    .clk        (clk),
    .rst_n      (rst_i),
    .bit_in     (t1_bit),
    .adv        (t1_adv),
    .fsync      (t1_fsync),
    .banks      (banks),
    .full_bank  (full_bank),
    .have_frame (have_frame)
  );

  logic [PW-1:0] pos_q, pos_n;
  logic          bank_q, bank_n;
  logic          ok_q, ok_n;
  logic          pcm_q, pcm_n;
  logic          unasg_q, unasg_n;
  pos_kind_e     kind;
  logic [IW-1:0] src_idx;

  e1_slot_map #(
    .SLOT_BITS (SLOT_BITS),
    .T1_SLOTS  (T1_SLOTS),
    .E1_SLOTS  (E1_SLOTS),
    .SIG_SLOT  (SIG_SLOT),
    .FBIT_SLOT (FBIT_SLOT)
  ) u_map (
    .pos     (pos_n),
    .kind    (kind),
    .src_idx (src_idx)
  );

  always_comb begin
    pos_n   = pos_q;
    bank_n  = bank_q;
    ok_n    = ok_q;
    pcm_n   = pcm_q;
    unasg_n = unasg_q;
    if (e1_adv) begin
      if (e1_fsync) begin
        pos_n  = '0;
        bank_n = full_bank;
        ok_n   = have_frame;
      end else begin
        pos_n = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
      end
      pcm_n   = 1'b1;
      unasg_n = 1'b1;
      if (en) begin
        unasg_n = 1'b0;
        unique case (kind)
          POS_DATA:  pcm_n = ok_n ? banks[bank_n][src_idx] : 1'b1;
          POS_FBIT:  pcm_n = ok_n ? banks[bank_n][0] : 1'b1;
          POS_FILL:  pcm_n = 1'b1;
          default:   unasg_n = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pos_q   <= LAST_POS;
      bank_q  <= 1'b0;
      ok_q    <= 1'b0;
      pcm_q   <= 1'b1;
      unasg_q <= 1'b1;
    end else begin
      pos_q   <= pos_n;
      bank_q  <= bank_n;
      ok_q    <= ok_n;
      pcm_q   <= pcm_n;
      unasg_q <= unasg_n;
    end
  end

  assign e1_pcm   = pcm_q;
  assign e1_unasg = unasg_q;
endmodule

// File: rtl/t1e1_embed_mapper_chk.sv
module t1e1_embed_mapper_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic e1_adv,
  input logic e1_fsync,
  input logic e1_pcm,
  input logic e1_unasg
);
  // R7: no strobe, no change
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !e1_adv |=> $stable(e1_pcm) && $stable(e1_unasg));

  // R6: disabled embedding gives fill and unassigned marker
  a_r6_disabled_fill: assert property (@(posedge clk) disable iff (!rst_n)
    e1_adv && !en |=> e1_pcm && e1_unasg);

  // R5: E1 slot 0 is unassigned
  a_r5_slot0_unasg: assert property (@(posedge clk) disable iff (!rst_n)
    e1_adv && e1_fsync |=> e1_unasg);

  // R5: unassigned slots carry all ones
  a_r5_unasg_fill: assert property (@(posedge clk) disable iff (!rst_n)
    e1_unasg |-> e1_pcm);
endmodule

bind t1e1_embed_mapper t1e1_embed_mapper_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .e1_adv   (e1_adv),
  .e1_fsync (e1_fsync),
  .e1_pcm   (e1_pcm),
  .e1_unasg (e1_unasg)
);

// File: tb/t1e1_embed_mapper_test.sv
`timescale 1ns/1ps
module t1e1_embed_mapper_test;
  localparam int FB = 193;
  localparam int EB = 256;

  logic clk, rst_n, en, t1_bit, t1_adv, t1_fsync, e1_adv, e1_fsync;
  logic e1_pcm, e1_unasg;
  int   vectors = 0;
  int   errors  = 0;
  bit   done    = 0;

  t1e1_embed_mapper uut (
    .clk(clk), .rst_n(rst_n), .en(en), .t1_bit(t1_bit), .t1_adv(t1_adv),
    .t1_fsync(t1_fsync), .e1_adv(e1_adv), .e1_fsync(e1_fsync),
    .e1_pcm(e1_pcm), .e1_unasg(e1_unasg)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // seed[9:2], framing bit[1], enable[0]
  localparam logic [9:0] VEC [4] = '{
    {8'hA5, 1'b1, 1'b1},
    {8'h3C, 1'b0, 1'b1},
    {8'h00, 1'b1, 1'b1},
    {8'hFF, 1'b0, 1'b1}
  };

  function automatic logic [FB-1:0] mk(input logic [7:0] seed, input logic fb);
    logic [FB-1:0] f;
    f = '0;
    f[0] = fb;
    for (int k = 1; k <= 24; k++) begin
      logic [7:0] b;
      b = seed ^ 8'(k * 29);
      for (int j = 0; j < 8; j++) f[1 + 8 * (k - 1) + j] = b[7 - j];
    end
    return f;
  endfunction

  // returns {unassigned, data}
  function automatic logic [1:0] expv(input logic [FB-1:0] fr, input bit have,
                                      input bit en_v, input int p);
    int s, b, t;
    s = p / 8;
    b = p % 8;
    if (!en_v) return 2'b11;
    if (s == 0 || s == 16 || s > 26) return 2'b11;
    if (s == 26) return {1'b0, (b == 0 && have) ? fr[0] : 1'b1};
    t = (s < 16) ? s : s - 1;
    return {1'b0, have ? fr[1 + 8 * (t - 1) + b] : 1'b1};
  endfunction

  function automatic string req_of(input int p, input bit en_v);
    int s;
    s = p / 8;
    if (!en_v) return "R6";
    if (s == 26) return "R4";
    if (s == 0 || s == 16 || s > 26) return "R5";
    if (s < 16) return "R2";
    return "R3";
  endfunction

  task automatic chk(input string rq, input logic [1:0] act, input logic [1:0] exp_v, input int p);
    vectors++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s pos %0d: unasg/pcm actual %b expected %b", rq, p, act, exp_v);
    end
  endtask

  task automatic send_t1(input logic [FB-1:0] fr, input int n, input bit with_sync);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      t1_adv   = 1'b1;
      t1_fsync = with_sync && (i == 0);
      t1_bit   = fr[i];
    end
    @(negedge clk);
    t1_adv = 1'b0;
    t1_fsync = 1'b0;
  endtask

  task automatic play(input logic [FB-1:0] fr, input bit have, input int from,
                      input int to, input bit en_v, input string tag);
    for (int p = from; p <= to; p++) begin
      @(negedge clk);
      en       = en_v;
      e1_adv   = 1'b1;
      e1_fsync = (p == 0);
      @(posedge clk);
      #1;
      if (tag == "") chk(req_of(p, en_v), {e1_unasg, e1_pcm}, expv(fr, have, en_v, p), p);
      else           chk(tag, {e1_unasg, e1_pcm}, expv(fr, have, en_v, p), p);
    end
    @(negedge clk);
    e1_adv = 1'b0;
    e1_fsync = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [FB-1:0] fa, fb_, fc, junk;
    logic [1:0] held;
    rst_n = 1'b0; en = 1'b1; t1_bit = 1'b0; t1_adv = 1'b0; t1_fsync = 1'b0;
    e1_adv = 1'b0; e1_fsync = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {e1_unasg, e1_pcm}, 2'b11, -1);

    // R10 / R9: unframed bits are ignored, nothing becomes playable
    junk = mk(8'h5A, 1'b0);
    send_t1(junk, FB, 1'b0);
    play(junk, 1'b0, 0, EB - 1, 1'b1, "R9");

    // table walk: each entry loads a T1 frame and plays a full E1 frame
    for (int v = 0; v < 4; v++) begin
      fa = mk(VEC[v][9:2], VEC[v][1]);
      send_t1(fa, FB, 1'b1);
      play(fa, 1'b1, 0, EB - 1, VEC[v][0], "");
    end

    // R10: partial frame cut by a new strobe, then complete frame C
    fc = mk(8'h96, 1'b1);
    send_t1(mk(8'h11, 1'b0), 50, 1'b1);
    send_t1(fc, FB, 1'b1);
    play(fc, 1'b1, 0, EB - 1, 1'b1, "R10");

    // R8: new T1 frame completed mid E1 frame
    fa = mk(8'h4E, 1'b0);
    fb_ = mk(8'hC3, 1'b1);
    send_t1(fa, FB, 1'b1);
    play(fa, 1'b1, 0, 127, 1'b1, "R8");
    send_t1(fb_, FB, 1'b1);
    play(fa, 1'b1, 128, EB - 1, 1'b1, "R8");
    play(fb_, 1'b1, 0, EB - 1, 1'b1, "R8");

    // R7: outputs hold without a strobe
    play(fb_, 1'b1, 0, 72, 1'b1, "R7");
    held = {e1_unasg, e1_pcm};
    repeat (6) @(negedge clk);
    chk("R7", {e1_unasg, e1_pcm}, held, 72);
    play(fb_, 1'b1, 73, EB - 1, 1'b1, "R7");

    // R6: enable dropped mid frame
    play(fb_, 1'b1, 0, 99, 1'b1, "R6");
    play(fb_, 1'b1, 100, EB - 1, 1'b0, "R6");
    en = 1'b1;

    // R1: reset again returns the idle state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", {e1_unasg, e1_pcm}, 2'b11, -1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    play(fb_, 1'b0, 0, EB - 1, 1'b1, "R9");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule